// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the operand effective address for an 8-bit big-endian processor core. It handles three addressing kinds: a page-relative short form, a full 16-bit absolute form, and a family of pointer-relative forms steered by one postbyte. The instruction decoder pulses `start` with the addressing kind. The block then pulls the instruction bytes it needs from a byte stream over a valid/ready handshake. When an indirect form is selected, it reads one 16-bit word through a simple request/acknowledge read port.

Alongside the address, the block reports three things: the write-back for an auto-modified pointer, the extra cycle penalty of the chosen form, and whether the postbyte was illegal. All of these are valid during the single cycle in which `done` is high. The register inputs (`acc_a`, `acc_b`, `dpage`, `pc_next` and the four pointers) must be held stable from `start` until `done`. The 16-bit accumulator pair is taken as `{acc_a, acc_b}`.

Top module: `idx_ea_unit`

## Requirements
- R1: In indexed kind, postbyte bits 6:5 pick the base pointer: 00 = `ptr_x`, 01 = `ptr_y`, 10 = `ptr_u`, 11 = `ptr_s`. `wb_sel` carries the same code.
- R2: A postbyte with bit 7 = 0 gives base plus bits 4:0 taken as a signed 5-bit value. The penalty is 1 cycle.
- R3: With bit 7 = 1, bits 3:0 = 0000 or 0001 use the base and then write back base+1 or base+2. Bits 3:0 = 0010 or 0011 use and write back base-1 or base-2. The penalties are 2, 3, 2 and 3 cycles.
- R4: Sub-mode 0100 uses the base unchanged with a penalty of 0. Sub-mode 0101 adds sign-extended `acc_b` and sub-mode 0110 adds sign-extended `acc_a`, each with a penalty of 1.
- R5: Sub-mode 1000 adds one sign-extended stream byte (penalty 1). Sub-mode 1001 adds a big-endian 16-bit stream offset (penalty 4). Sub-mode 1011 adds `{acc_a, acc_b}` (penalty 4).
- R6: Sub-modes 1100 and 1101 add a signed 8-bit or 16-bit stream offset to `pc_next + number of offset bytes`. Here `pc_next` is the address just after the postbyte. The penalty is 1.
- R7: When postbyte bit 7 = 1 and bit 4 = 1, the computed address is presented on `mem_addr` with `mem_req`. The acknowledged `mem_rdata` becomes `ea`, and 3 is added to the penalty. No read is made in any other case.
- R8: Sub-modes 0111, 1010, 1110 and 1111 are illegal, as are 0000 or 0010 with bit 4 = 1. An illegal postbyte gives `illegal`=1 with `done` after the postbyte alone, with `wb_en`=0, `extra`=0, `ea`=0 and no memory read.
- R9: `amode` 00 (page) gives `ea` = {`dpage`, one stream byte}. `amode` 01 (absolute) gives `ea` = two stream bytes, high byte first. Both have a penalty of 0 and no write-back. `amode` 1x is the indexed kind.
- R10: `done` is a one-cycle pulse. `in_ready` is high only while the block is collecting bytes. All address arithmetic wraps modulo 2^16.
- R11: `wb_en` is high only with `done`, and only for the legal sub-modes 0000 to 0011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one address computation (accepted when idle) |
| amode | input | 2 | Addressing kind: 00 page, 01 absolute, 1x indexed |
| in_valid | input | 1 | Stream byte valid |
| in_byte | input | 8 | Stream byte |
| in_ready | output | 1 | Block accepts a stream byte |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| dpage | input | 8 | Direct-page high byte |
| pc_next | input | 16 | Address following the postbyte |
| ptr_x | input | 16 | Pointer X |
| ptr_y | input | 16 | Pointer Y |
| ptr_u | input | 16 | Pointer U |
| ptr_s | input | 16 | Pointer S |
| mem_req | output | 1 | Indirect word read request |
| mem_addr | output | 16 | Indirect word address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 16 | Big-endian word read |
| done | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address |
| wb_en | output | 1 | Pointer write-back enable |
| wb_sel | output | 2 | Pointer to write back |
| wb_val | output | 16 | Write-back value |
| extra | output | 4 | Extra cycle penalty |
| illegal | output | 1 | Illegal postbyte |

## Verification
A wrong postbyte held internally shows up at the next `done` in several ways: the wrong pointer, a wrong penalty, a spurious write-back, or a byte count that is wrong and leaves `in_ready` high too long or drops it too soon. A fault in the byte stream register shows up in the `ea` of the same operation. A fault in the indirect path shows up as a `mem_req` that never appears, appears for a non-indirect form, or moves its address before the acknowledge. Each fault therefore appears no later than the `done` of the operation that triggers it.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_IND   = 2'd2,
    ST_DONE  = 2'd3
  } ea_state_e;

  typedef struct packed {
    logic [1:0] base;
    logic       short_f;
    logic       ind;
    logic [3:0] sub;
    logic [1:0] nofs;
    logic [3:0] cost;
    logic       bad;
    logic       wb;
  } pb_dec_t;
endpackage

// File: rtl/idx_pb_decode.sv
module idx_pb_decode
  import idx_ea_pkg::*;
(
  input  logic [7:0] pb,
  output pb_dec_t    dec
);
  always_comb begin
    dec         = '0;
    dec.base    = pb[6:5];
    dec.short_f = ~pb[7];
    dec.ind     = pb[7] & pb[4];
    dec.sub     = pb[3:0];
    if (!pb[7]) begin
      dec.cost = 4'd1;
    end else begin
      unique case (pb[3:0])
        4'b0000: begin dec.cost = 4'd2; dec.wb = 1'b1; dec.bad = pb[4]; end
        4'b0001: begin dec.cost = 4'd3; dec.wb = 1'b1; end
        4'b0010: begin dec.cost = 4'd2; dec.wb = 1'b1; dec.bad = pb[4]; end
        4'b0011: begin dec.cost = 4'd3; dec.wb = 1'b1; end
        4'b0100: dec.cost = 4'd0;
        4'b0101, 4'b0110: dec.cost = 4'd1;
        4'b1000: begin dec.cost = 4'd1; dec.nofs = 2'd1; end
        4'b1001: begin dec.cost = 4'd4; dec.nofs = 2'd2; end
        4'b1011: dec.cost = 4'd4;
        4'b1100: begin dec.cost = 4'd1; dec.nofs = 2'd1; end
        4'b1101: begin dec.cost = 4'd1; dec.nofs = 2'd2; end
        default: dec.bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/idx_addr_calc.sv
module idx_addr_calc
  import idx_ea_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W
) (
  input  pb_dec_t         dec,
  input  logic [4:0]      pb_lo,
  input  logic [AW-1:0]   base_val,
  input  logic [BW-1:0]   acc_a,
  input  logic [BW-1:0]   acc_b,
  input  logic [AW-1:0]   pc_next,
  input  logic [AW-1:0]   ofs,
  output logic [AW-1:0]   ea_pre,
  output logic [AW-1:0]   wb_val
);
  logic [AW-1:0] sx5, sxa, sxb, sxo;
  assign sx5 = {{(AW-5){pb_lo[4]}}, pb_lo};
  assign sxa = {{(AW-BW){acc_a[BW-1]}}, acc_a};
  assign sxb = {{(AW-BW){acc_b[BW-1]}}, acc_b};
  assign sxo = {{(AW-BW){ofs[BW-1]}}, ofs[BW-1:0]};

  always_comb begin
    ea_pre = base_val;
    wb_val = base_val;
    if (dec.short_f) begin
      ea_pre = base_val + sx5;
    end else begin
      unique case (dec.sub)
        4'b0000: wb_val = base_val + AW'(1);
        4'b0001: wb_val = base_val + AW'(2);
        4'b0010: begin ea_pre = base_val - AW'(1); wb_val = ea_pre; end
        4'b0011: begin ea_pre = base_val - AW'(2); wb_val = ea_pre; end
        4'b0101: ea_pre = base_val + sxb;
        4'b0110: ea_pre = base_val + sxa;
        4'b1000: ea_pre = base_val + sxo;
        4'b1001: ea_pre = base_val + ofs;
        4'b1011: ea_pre = base_val + {acc_a, acc_b};
        4'b1100: ea_pre = pc_next + AW'(1) + sxo;
        4'b1101: ea_pre = pc_next + AW'(2) + ofs;
        default: ea_pre = base_val;
      endcase
    end
  end
endmodule

// File: rtl/idx_ea_unit.sv
module idx_ea_unit
  import idx_ea_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    amode,
  input  logic          in_valid,
  input  logic [BW-1:0] in_byte,
  output logic          in_ready,
  input  logic [BW-1:0] acc_a,
  input  logic [BW-1:0] acc_b,
  input  logic [BW-1:0] dpage,
  input  logic [AW-1:0] pc_next,
  input  logic [AW-1:0] ptr_x,
  input  logic [AW-1:0] ptr_y,
  input  logic [AW-1:0] ptr_u,
  input  logic [AW-1:0] ptr_s,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          wb_en,
  output logic [1:0]    wb_sel,
  output logic [AW-1:0] wb_val,
  output logic [3:0]    extra,
  output logic          illegal
);
  localparam int NPTR = 4;

  ea_state_e     st_q, st_d;
  logic [1:0]    mode_q, mode_d;
  logic [BW-1:0] pb_q, pb_d;
  logic [AW-1:0] ofs_q, ofs_d;
  logic [1:0]    got_q, got_d;
  logic [AW-1:0] ind_q, ind_d;
  logic          en_st, en_mode, en_pb, en_ofs, en_got, en_ind;

  logic [AW-1:0] ptr_arr [NPTR];
  logic [BW-1:0] pb_cur;
  pb_dec_t       dec;
  logic [AW-1:0] calc_ea;
  logic [1:0]    need;
  logic          take, last, is_idx;

  assign ptr_arr[0] = ptr_x;
  assign ptr_arr[1] = ptr_y;
  assign ptr_arr[2] = ptr_u;
  assign ptr_arr[3] = ptr_s;

  assign is_idx = mode_q[1];
  assign pb_cur = (got_q == 2'd0) ? in_byte : pb_q;

  idx_pb_decode u_dec (.pb(pb_cur), .dec(dec));

  idx_addr_calc #(.AW(AW), .BW(BW)) u_calc (
    .dec(dec), .pb_lo(pb_cur[4:0]), .base_val(ptr_arr[dec.base]),
    .acc_a(acc_a), .acc_b(acc_b), .pc_next(pc_next), .ofs(ofs_q),
    .ea_pre(calc_ea), .wb_val(wb_val)
  );

  always_comb begin
    if (is_idx) need = dec.bad ? 2'd1 : 2'(2'd1 + dec.nofs);
    else        need = mode_q[0] ? 2'd2 : 2'd1;
  end

  assign take = (st_q == ST_FETCH) && in_valid;
  assign last = take && (2'(got_q + 2'd1) == need);

  always_comb begin
    st_d = st_q;   mode_d = amode;  pb_d = in_byte;
    ofs_d = {ofs_q[AW-BW-1:0], in_byte};
    got_d = '0;    ind_d = mem_rdata;
    en_st = 1'b0;  en_mode = 1'b0;  en_pb = 1'b0;
    en_ofs = 1'b0; en_got = 1'b0;   en_ind = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d = ST_FETCH; en_st = 1'b1; en_mode = 1'b1; en_got = 1'b1;
      end
      ST_FETCH: if (take) begin
        got_d  = 2'(got_q + 2'd1);
        en_got = 1'b1;
        if (is_idx && got_q == 2'd0) en_pb = 1'b1;
        else                         en_ofs = 1'b1;
        if (last) begin
          en_st = 1'b1;
          st_d  = (is_idx && dec.ind && !dec.bad) ? ST_IND : ST_DONE;
        end
      end
      ST_IND: if (mem_ack) begin
        st_d = ST_DONE; en_st = 1'b1; en_ind = 1'b1;
      end
      default: begin st_d = ST_IDLE; en_st = 1'b1; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= '0;
      pb_q   <= '0;
      ofs_q  <= '0;
      got_q  <= '0;
      ind_q  <= '0;
    end else begin
      if (en_st)   st_q   <= st_d;
      if (en_mode) mode_q <= mode_d;
      if (en_pb)   pb_q   <= pb_d;
      if (en_ofs)  ofs_q  <= ofs_d;
      if (en_got)  got_q  <= got_d;
      if (en_ind)  ind_q  <= ind_d;
    end
  end

  assign in_ready = (st_q == ST_FETCH);
  assign mem_req  = (st_q == ST_IND);
  assign mem_addr = calc_ea;
  assign done     = (st_q == ST_DONE);
  assign wb_sel   = dec.base;
  assign wb_en    = done && is_idx && !dec.bad && dec.wb;
  assign illegal  = done && is_idx && dec.bad;

  always_comb begin
    if (!is_idx)      ea = mode_q[0] ? ofs_q : {dpage, ofs_q[BW-1:0]};
    else if (dec.bad) ea = '0;
    else if (dec.ind) ea = ind_q;
    else              ea = calc_ea;
    if (is_idx && !dec.bad) extra = dec.cost + (dec.ind ? 4'd3 : 4'd0);
    else                    extra = 4'd0;
  end
endmodule

// File: rtl/idx_ea_chk.sv
module idx_ea_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          in_ready,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          wb_en,
  input logic          illegal,
  input logic [3:0]    extra
);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ready_not_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !done && !mem_req);

  p_wb_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done && !illegal);

  p_illegal_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done && !wb_en && extra == 4'd0);

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  p_req_to_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> done);
endmodule

bind idx_ea_unit idx_ea_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .in_ready(in_ready),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .wb_en(wb_en), .illegal(illegal), .extra(extra)
);

// File: tb/idx_ea_unit_tb_top.sv
module idx_ea_unit_tb_top;
  localparam int TCLK = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] amode = 2'b00;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_ready;
  logic [7:0] acc_a = 8'h80, acc_b = 8'h05, dpage = 8'h12;
  logic [15:0] pc_next = 16'h8000;
  logic [15:0] ptr_x = 16'h1000, ptr_y = 16'h2000, ptr_u = 16'h3000, ptr_s = 16'h4000;
  logic mem_req;
  logic [15:0] mem_addr;
  logic mem_ack = 1'b0;
  logic [15:0] mem_rdata = 16'h0000;
  logic done, wb_en, illegal;
  logic [15:0] ea, wb_val;
  logic [1:0] wb_sel;
  logic [3:0] extra;

  int n_chk = 0, n_bad = 0, n_reads = 0;
  logic [15:0] r_ea, r_wbval;
  logic r_wben, r_ill;
  logic [1:0] r_sel;
  logic [3:0] r_extra;

  always #(TCLK/2) clk = ~clk;

  idx_ea_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .amode(amode),
    .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .acc_a(acc_a), .acc_b(acc_b), .dpage(dpage), .pc_next(pc_next),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_u(ptr_u), .ptr_s(ptr_s),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .done(done), .ea(ea), .wb_en(wb_en),
    .wb_sel(wb_sel), .wb_val(wb_val), .extra(extra), .illegal(illegal)
  );

  function automatic logic [15:0] memf(input logic [15:0] a);
    return a ^ 16'h5A3C;
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        mem_ack = 1'b1; mem_rdata = memf(mem_addr); n_reads++;
      end else begin
        mem_ack = 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] m, input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] b2, input int nb);
    logic [7:0] bs [3];
    bs[0] = b0; bs[1] = b1; bs[2] = b2;
    @(negedge clk);
    start = 1'b1; amode = m;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < nb; i++) begin
      in_valid = 1'b1; in_byte = bs[i];
      for (int w = 0; w < 50 && !in_ready; w++) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    for (int k = 0; k < 20 && !done; k++) @(negedge clk);
    chk("R10 done seen", {15'd0, done}, 16'd1);
    chk("R10 ready low at done", {15'd0, in_ready}, 16'd0);
    r_ea = ea; r_wbval = wb_val; r_wben = wb_en; r_ill = illegal;
    r_sel = wb_sel; r_extra = extra;
    @(negedge clk);
    chk("R10 done pulse", {15'd0, done}, 16'd0);
  endtask

  task automatic expect_res(input string tag, input logic [15:0] e_ea, input logic [3:0] e_x,
                            input logic e_wb, input logic [15:0] e_wbv);
    chk({tag, " ea"}, r_ea, e_ea);
    chk({tag, " extra"}, {12'd0, r_extra}, {12'd0, e_x});
    chk({tag, " wb_en"}, {15'd0, r_wben}, {15'd0, e_wb});
    if (e_wb) chk({tag, " wb_val"}, r_wbval, e_wbv);
    chk({tag, " illegal"}, {15'd0, r_ill}, 16'd0);
  endtask

  task automatic t_reset;
    chk("R10 reset done", {15'd0, done}, 16'd0);
    chk("R10 reset ready", {15'd0, in_ready}, 16'd0);
    chk("R7 reset req", {15'd0, mem_req}, 16'd0);
  endtask

  task automatic t_page_abs;
    run_op(2'b00, 8'h34, 8'h00, 8'h00, 1); expect_res("R9 page", 16'h1234, 4'd0, 1'b0, 16'h0);
    run_op(2'b01, 8'hAB, 8'hCD, 8'h00, 2); expect_res("R9 abs", 16'hABCD, 4'd0, 1'b0, 16'h0);
  endtask

  task automatic t_short;
    run_op(2'b10, 8'h30, 8'h00, 8'h00, 1); expect_res("R2 short neg Y", 16'h1FF0, 4'd1, 1'b0, 16'h0);
    run_op(2'b10, 8'h6F, 8'h00, 8'h00, 1); expect_res("R1 short pos S", 16'h400F, 4'd1, 1'b0, 16'h0);
  endtask

  task automatic t_auto;
    run_op(2'b10, 8'h80, 8'h00, 8'h00, 1); expect_res("R3 inc1 X", 16'h1000, 4'd2, 1'b1, 16'h1001);
    chk("R1 sel X", {14'd0, r_sel}, 16'd0);
    run_op(2'b10, 8'hC1, 8'h00, 8'h00, 1); expect_res("R3 inc2 U", 16'h3000, 4'd3, 1'b1, 16'h3002);
    chk("R1 sel U", {14'd0, r_sel}, 16'd2);
    run_op(2'b10, 8'hA2, 8'h00, 8'h00, 1); expect_res("R3 dec1 Y", 16'h1FFF, 4'd2, 1'b1, 16'h1FFF);
    chk("R1 sel Y", {14'd0, r_sel}, 16'd1);
    run_op(2'b10, 8'hE3, 8'h00, 8'h00, 1); expect_res("R3 dec2 S", 16'h3FFE, 4'd3, 1'b1, 16'h3FFE);
    chk("R1 sel S", {14'd0, r_sel}, 16'd3);
  endtask

  task automatic t_acc;
    run_op(2'b10, 8'h84, 8'h00, 8'h00, 1); expect_res("R4 R11 plain", 16'h1000, 4'd0, 1'b0, 16'h0);
    run_op(2'b10, 8'h85, 8'h00, 8'h00, 1); expect_res("R4 accB", 16'h1005, 4'd1, 1'b0, 16'h0);
    run_op(2'b10, 8'h86, 8'h00, 8'h00, 1); expect_res("R4 accA", 16'h0F80, 4'd1, 1'b0, 16'h0);
  endtask

  task automatic t_ofs;
    run_op(2'b10, 8'h88, 8'hF0, 8'h00, 2); expect_res("R5 ofs8", 16'h0FF0, 4'd1, 1'b0, 16'h0);
    run_op(2'b10, 8'h89, 8'h12, 8'h34, 3); expect_res("R5 ofs16", 16'h2234, 4'd4, 1'b0, 16'h0);
    run_op(2'b10, 8'h8B, 8'h00, 8'h00, 1); expect_res("R5 accD", 16'h9005, 4'd4, 1'b0, 16'h0);
  endtask

  task automatic t_pcrel;
    run_op(2'b10, 8'h8C, 8'h10, 8'h00, 2); expect_res("R6 pc8", 16'h8011, 4'd1, 1'b0, 16'h0);
    run_op(2'b10, 8'h8D, 8'hFF, 8'hFE, 3); expect_res("R6 pc16", 16'h8000, 4'd1, 1'b0, 16'h0);
  endtask

  task automatic t_indirect;
    int r0;
    r0 = n_reads;
    run_op(2'b10, 8'h94, 8'h00, 8'h00, 1); expect_res("R7 ind plain", memf(16'h1000), 4'd3, 1'b0, 16'h0);
    run_op(2'b10, 8'h99, 8'h00, 8'h10, 3); expect_res("R7 ind ofs16", memf(16'h1010), 4'd7, 1'b0, 16'h0);
    run_op(2'b10, 8'h91, 8'h00, 8'h00, 1); expect_res("R7 R3 ind inc2", memf(16'h1000), 4'd6, 1'b1, 16'h1002);
    chk("R7 read count", 16'(n_reads - r0), 16'd3);
    r0 = n_reads;
    run_op(2'b10, 8'h84, 8'h00, 8'h00, 1);
    chk("R7 no read direct form", 16'(n_reads - r0), 16'd0);
  endtask

  task automatic t_illegal;
    logic [7:0] pbs [4];
    int r0;
    pbs[0] = 8'h87; pbs[1] = 8'h90; pbs[2] = 8'hB2; pbs[3] = 8'h8F;
    for (int i = 0; i < 4; i++) begin
      r0 = n_reads;
      run_op(2'b10, pbs[i], 8'h00, 8'h00, 1);
      chk("R8 illegal flag", {15'd0, r_ill}, 16'd1);
      chk("R8 no wb", {15'd0, r_wben}, 16'd0);
      chk("R8 extra zero", {12'd0, r_extra}, 16'd0);
      chk("R8 ea zero", r_ea, 16'h0000);
      chk("R8 no read", 16'(n_reads - r0), 16'd0);
    end
  endtask

  task automatic t_wrap;
    ptr_x = 16'hFFFF;
    run_op(2'b10, 8'h81, 8'h00, 8'h00, 1); expect_res("R10 wrap inc2", 16'hFFFF, 4'd3, 1'b1, 16'h0001);
    ptr_x = 16'h0000;
    run_op(2'b10, 8'h82, 8'h00, 8'h00, 1); expect_res("R10 wrap dec1", 16'hFFFF, 4'd2, 1'b1, 16'hFFFF);
    ptr_x = 16'h1000;
  endtask

  bit finished = 1'b0;

  initial begin
    #(TCLK * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_page_abs();
    t_short();
    t_auto();
    t_acc();
    t_ofs();
    t_pcrel();
    t_indirect();
    t_illegal();
    t_wrap();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule